// File: doc/BRIEF.md
# Programmable Input Filter with Debounce and Glitch Detection

This block conditions one already-synchronized digital input before it feeds a counter. Software picks one of two behaviours. As a debounce filter, the block holds its output level and adopts a new input level only after the input has stayed at that level for a programmed number of clock cycles. Any return to the old level restarts that wait. As a glitch detector, the block passes the input through after one register stage. It raises a sticky flag whenever an active pulse ends before the programmed time has run out.

The programmed time is one of sixteen steps that rise roughly logarithmically, from 500 ns to 25 ms. The cycle counts are derived at elaboration from the clock frequency parameter (48 MHz by default). A polarity select makes the block positive- or negative-edge sensitive: it inverts the output and chooses which input level counts as the active pulse. With the filter disabled, the input is passed through after one register stage and glitches are not flagged.

Top module: `input_filter`

## Requirements
- R1: While rst_ni is low, the internal level is 0, so sig_o equals pol_i, and glitch_o is 0.
- R2: Time select k gives a filter time N of the following cycle counts at the default 48 MHz, for k = 0..15: 24, 48, 96, 240, 480, 960, 2400, 4800, 9600, 24000, 48000, 96000, 240000, 480000, 960000, 1200000.
- R3: With en_i=1 and mode_i=0 (debounce), the internal level takes a new input value at the N-th consecutive rising clock edge that samples sig_i different from the level. A sample equal to the level restarts the count. Shorter runs leave the level unchanged.
- R4: In debounce mode glitch_o is never set.
- R5: With en_i=1 and mode_i=1 (glitch detect), the level follows sig_i one clock later. An active pulse (sig_i=1 when pol_i=0, sig_i=0 when pol_i=1) that was sampled on fewer than N edges sets glitch_o at the first edge that samples the inactive level. A pulse sampled on N or more edges does not set it.
- R6: glitch_o stays set until an edge samples glitch_clr_i=1, which clears it. If a new glitch ends on that same edge, the flag stays set.
- R7: With en_i=0, the level follows sig_i one clock later whatever the mode, and glitch_o is not set.
- R8: sig_o is the internal level XOR pol_i, so pol_i=1 gives an inverted output and selects the low level as active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | 1 | Synchronized raw input |
| en_i | input | 1 | 1 enables filtering, 0 passes the input through |
| mode_i | input | 1 | 0 debounce, 1 glitch detect |
| pol_i | input | 1 | 0 positive edge sensitive, 1 negative edge sensitive |
| time_sel_i | input | 4 | Filter time step index |
| glitch_clr_i | input | 1 | Clears the glitch flag |
| sig_o | output | 1 | Conditioned output |
| glitch_o | output | 1 | Sticky glitch flag |

## Verification
The hardest situation to reach is the edge on which a short pulse ends while a clear of the flag is requested. Set and clear must land on the same clock edge for the priority rule to show. The bench drives a three-cycle pulse and raises the clear request in the very cycle the input returns to its inactive level, so both are sampled by one edge. Exact debounce thresholds are reached by holding the input for N-1 and then N edges at several time steps. A restart is provoked by a one-cycle bounce placed inside an otherwise long enough run.

// File: rtl/input_filter_pkg.sv
package input_filter_pkg;
  localparam int unsigned STEPS = 16;
  localparam int unsigned SEL_W = $clog2(STEPS);

  typedef enum logic {
    MODE_DEBOUNCE = 1'b0,
    MODE_GLITCH   = 1'b1
  } filt_mode_e;

  // 1-2-5 ladder ending at 25 ms
  function automatic longint unsigned step_ns(int unsigned idx);
    case (idx)
      0:       return 64'd500;
      1:       return 64'd1_000;
      2:       return 64'd2_000;
      3:       return 64'd5_000;
      4:       return 64'd10_000;
      5:       return 64'd20_000;
      6:       return 64'd50_000;
      7:       return 64'd100_000;
      8:       return 64'd200_000;
      9:       return 64'd500_000;
      10:      return 64'd1_000_000;
      11:      return 64'd2_000_000;
      12:      return 64'd5_000_000;
      13:      return 64'd10_000_000;
      14:      return 64'd20_000_000;
      default: return 64'd25_000_000;
    endcase
  endfunction

  function automatic longint unsigned step_cycles(longint unsigned clk_khz, int unsigned idx);
    return (clk_khz * step_ns(idx)) / 64'd1_000_000;
  endfunction
endpackage

// File: rtl/filt_step_rom.sv
module filt_step_rom
  import input_filter_pkg::*;
#(
  parameter longint unsigned CLK_KHZ = 48000,
  parameter int unsigned     CNT_W   = 21
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] cycles_o
);
  logic [CNT_W-1:0] tbl [STEPS];

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    localparam longint unsigned CYC = step_cycles(CLK_KHZ, i);
    assign tbl[i] = CNT_W'(CYC);
  end

  assign cycles_o = tbl[sel_i];
endmodule

// File: rtl/filt_debounce.sv
module filt_debounce #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             sig_i,
  input  logic             level_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             take_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             diff;
  logic             done;

  assign diff   = sig_i != level_i;
  assign done   = (cnt_q + ONE) >= n_i;
  assign take_o = run_i && diff && done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || !diff) cnt_q <= '0;
    else if (done)            cnt_q <= '0;
    else                      cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/filt_glitch.sv
module filt_glitch #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             arm_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] run_q;
  logic             prev_act_q;
  logic             flag_q;
  logic             hit;

  // pulse just ended and was short
  assign hit = arm_i && prev_act_q && !act_i && (run_q < n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= '0;
      prev_act_q <= 1'b0;
    end else begin
      prev_act_q <= act_i;
      if (!act_i)           run_q <= '0;
      else if (run_q != '1) run_q <= run_q + ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/input_filter.sv
module input_filter
  import input_filter_pkg::*;
#(
  parameter longint unsigned CLK_KHZ = 48000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             pol_i,
  input  logic [SEL_W-1:0] time_sel_i,
  input  logic             glitch_clr_i,
  output logic             sig_o,
  output logic             glitch_o
);
  localparam longint unsigned MAX_CYC = step_cycles(CLK_KHZ, STEPS - 1);
  localparam int unsigned     CNT_W   = $clog2(MAX_CYC + 1);

  filt_mode_e       mode;
  logic [CNT_W-1:0] n_cyc;
  logic             level_q;
  logic             take;
  logic             deb_run;
  logic             gl_arm;

  assign mode    = filt_mode_e'(mode_i);
  assign deb_run = en_i && (mode == MODE_DEBOUNCE);
  assign gl_arm  = en_i && (mode == MODE_GLITCH);

  filt_step_rom #(.CLK_KHZ(CLK_KHZ), .CNT_W(CNT_W)) i_rom (
    .sel_i    (time_sel_i),
    .cycles_o (n_cyc)
  );

  filt_debounce #(.CNT_W(CNT_W)) i_deb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (deb_run),
    .sig_i   (sig_i),
    .level_i (level_q),
    .n_i     (n_cyc),
    .take_o  (take)
  );

  filt_glitch #(.CNT_W(CNT_W)) i_gl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (sig_i ^ pol_i),
    .arm_i  (gl_arm),
    .clr_i  (glitch_clr_i),
    .n_i    (n_cyc),
    .flag_o (glitch_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           level_q <= 1'b0;
    else if (!deb_run)     level_q <= sig_i;
    else if (take)         level_q <= sig_i;
  end

  assign sig_o = level_q ^ pol_i;
endmodule

// File: rtl/input_filter_chk.sv
module input_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sig_i,
  input logic en_i,
  input logic mode_i,
  input logic glitch_clr_i,
  input logic glitch_o,
  input logic level_i
);
  // R3: debounce only ever moves the level to a sampled input value
  a_r3_level_from_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !mode_i) |=> (level_i == $past(level_i) || level_i == $past(sig_i)));

  // R3: a matching sample never moves the level
  a_r3_hold_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !mode_i && sig_i == level_i) |=> $stable(level_i));

  // R4 / R7: flag rises only when glitch detect was armed
  a_r4_no_flag_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && mode_i) |=> !$rose(glitch_o));

  // R6: sticky without clear
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glitch_o && !glitch_clr_i) |=> glitch_o);

  // R7: pass-through when disabled
  a_r7_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> level_i == $past(sig_i));

  // R5: glitch mode follows input with one cycle latency
  a_r5_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i) |=> level_i == $past(sig_i));
endmodule

bind input_filter input_filter_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sig_i        (sig_i),
  .en_i         (en_i),
  .mode_i       (mode_i),
  .glitch_clr_i (glitch_clr_i),
  .glitch_o     (glitch_o),
  .level_i      (level_q)
);

// File: tb/test_input_filter.sv
module test_input_filter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 12;

  typedef struct packed {
    logic       mode;
    logic       en;
    logic       pol;
    logic [3:0] sel;
    logic [11:0] len;
    logic       exp_seen;
    logic       exp_gl;
  } vec_t;

  // mode, en, pol, sel, len, output pulse seen, glitch flag
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 1'b0, 4'd0, 12'd23, 1'b0, 1'b0},  // R3 one short
    '{1'b0, 1'b1, 1'b0, 4'd0, 12'd24, 1'b1, 1'b0},  // R3 exact
    '{1'b0, 1'b1, 1'b1, 4'd0, 12'd30, 1'b1, 1'b0},  // R3 R8 inverted
    '{1'b0, 1'b1, 1'b0, 4'd1, 12'd47, 1'b0, 1'b0},  // R3 step 1 short
    '{1'b0, 1'b1, 1'b0, 4'd1, 12'd48, 1'b1, 1'b0},  // R3 step 1 exact
    '{1'b1, 1'b1, 1'b0, 4'd0, 12'd23, 1'b1, 1'b1},  // R5 short
    '{1'b1, 1'b1, 1'b0, 4'd0, 12'd24, 1'b1, 1'b0},  // R5 exact length
    '{1'b1, 1'b1, 1'b1, 4'd0, 12'd5,  1'b1, 1'b1},  // R5 R8 low pulse
    '{1'b1, 1'b1, 1'b0, 4'd1, 12'd47, 1'b1, 1'b1},  // R5 step 1 short
    '{1'b1, 1'b1, 1'b1, 4'd1, 12'd60, 1'b1, 1'b0},  // R5 step 1 long
    '{1'b1, 1'b0, 1'b0, 4'd0, 12'd3,  1'b1, 1'b0},  // R7 bypass
    '{1'b0, 1'b0, 1'b1, 4'd0, 12'd1,  1'b1, 1'b0}   // R7 R8 bypass
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sig = 1'b0;
  logic       en = 1'b1;
  logic       mode = 1'b0;
  logic       pol = 1'b0;
  logic [3:0] sel = 4'd0;
  logic       clr = 1'b0;
  logic       sig_o;
  logic       glitch_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  input_filter i_input_filter (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sig_i        (sig),
    .en_i         (en),
    .mode_i       (mode),
    .pol_i        (pol),
    .time_sel_i   (sel),
    .glitch_clr_i (clr),
    .sig_o        (sig_o),
    .glitch_o     (glitch_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic int n_of(logic [3:0] s);
    case (s)
      4'd0: return 24;
      4'd1: return 48;
      4'd2: return 96;
      default: return 240;
    endcase
  endfunction

  task automatic run_vec(vec_t v);
    int  n;
    logic seen;
    string req;
    n = n_of(v.sel);
    req = !v.en ? "R7" : (v.mode ? "R5" : "R3");
    mode = v.mode; en = v.en; pol = v.pol; sel = v.sel;
    sig = v.pol;
    repeat (2 * n + 10) tick();
    clr = 1'b1; tick(); clr = 1'b0;
    seen = 1'b0;
    sig = ~v.pol;
    for (int i = 0; i < int'(v.len); i++) begin tick(); seen |= sig_o; end
    sig = v.pol;
    for (int i = 0; i < n + 5; i++) begin tick(); seen |= sig_o; end
    check(req, seen, v.exp_seen);
    check(v.mode ? "R5 flag" : "R4 flag", glitch_o, v.exp_gl);
    check("R8 idle", sig_o, 1'b0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    #2;
    check("R1 sig_o", sig_o, 1'b0);
    check("R1 glitch_o", glitch_o, 1'b0);
    pol = 1'b1; #1;
    check("R1 R8 sig_o inverted", sig_o, 1'b1);
    pol = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R2 R3 exact threshold at step 0
    sig = 1'b1;
    repeat (23) tick();
    check("R3 before N", sig_o, 1'b0);
    tick();
    check("R2 R3 at N=24", sig_o, 1'b1);

    // R3 bounce restarts
    sig = 1'b0; repeat (20) tick();
    sig = 1'b1; tick();
    sig = 1'b0; repeat (23) tick();
    check("R3 restart hold", sig_o, 1'b1);
    tick();
    check("R3 restart done", sig_o, 1'b0);
    check("R4 no flag", glitch_o, 1'b0);

    // R2 steps 2 and 3
    for (int s = 2; s < 4; s++) begin
      sel = 4'(s);
      sig = ~sig_o;
      repeat (n_of(4'(s)) - 1) tick();
      check("R2 step before N", sig_o, ~sig);
      tick();
      check("R2 step at N", sig_o, sig);
    end

    // vector table
    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R5 one cycle latency
    mode = 1'b1; en = 1'b1; pol = 1'b0; sel = 4'd0; sig = 1'b0;
    repeat (60) tick();
    clr = 1'b1; tick(); clr = 1'b0;
    sig = 1'b1; #1;
    check("R5 no comb path", sig_o, 1'b0);
    tick();
    check("R5 latency", sig_o, 1'b1);
    sig = 1'b0; tick();

    // R6 sticky then set beats clear
    sig = 1'b1; repeat (3) tick();
    sig = 1'b0; tick();
    check("R6 set", glitch_o, 1'b1);
    sig = 1'b1; repeat (40) tick();
    sig = 1'b0; repeat (5) tick();
    check("R6 sticky", glitch_o, 1'b1);
    clr = 1'b1; tick(); clr = 1'b0;
    check("R6 clear", glitch_o, 1'b0);
    sig = 1'b1; repeat (3) tick();
    sig = 1'b0; clr = 1'b1; tick(); clr = 1'b0;
    check("R6 set wins", glitch_o, 1'b1);
    clr = 1'b1; tick(); clr = 1'b0;
    check("R6 clear again", glitch_o, 1'b0);

    // R7 latency in bypass
    en = 1'b0; mode = 1'b0;
    sig = 1'b1; tick();
    check("R7 latency", sig_o, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule